// File: doc/BRIEF.md
# Ramping Interval Pulse Generator

This block drives a single output line with a repeating train of one-cycle pulses whose spacing is fully predictable. The first gap after start-up is two clock periods. Each later gap is one period longer than the one before it, until a gap equal to the programmed limit has been produced. The sweep then starts again at two. With a limit of 6, the gaps are 2, 3, 4, 5, 6, 2, 3, and so on. Each gap is counted in clock periods from one pulse to the next.

The block is a stimulus source for interval-measuring logic such as pulse counters and time-stamping front ends. The expected interval sequence can be computed exactly, so a receiver can compare every measured gap against a known value. The limit and the run control are plain inputs, because no data flows into or out of the block. The output is a bare pulse line with no valid/ready handshake, and the generator never waits for a consumer.

Top module: `ramp_pulse_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pulse` is low after that edge. The internal counters return to their start values, so the first run after reset begins with a gap of 2.
- R2: `pulse` is high right after the first rising edge at which `enable` is sampled high and `rst` is low. This applies after a cycle with `enable` low, and after a cycle with `rst` high.
- R3: `pulse` is never high for two consecutive cycles.
- R4: The first gap after a start is 2 clock periods.
- R5: Within a sweep, each gap is exactly one clock period longer than the gap before it.
- R6: After a gap equal to the active limit has been produced, the next gap is 2.
- R7: A `max_value` of 0 or 1 is treated as 2, so every gap is 2.
- R8: The limit is sampled from `max_value` only at a start and at the pulse that ends a gap equal to the active limit. A change of `max_value` in the middle of a sweep does not alter the gaps of that sweep.
- R9: While `enable` is low, `pulse` stays low. The next start begins the sweep again at a gap of 2.
- R10: Every limit up to the full-scale value 2^VAL_W-1 is honoured, including the last gap of the sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; high lets the pulse train run, low stops it and rewinds the sweep |
| max_value | input | VAL_W | Largest gap in clock periods; values below 2 act as 2 |
| pulse | output | 1 | One-cycle output pulses spaced by the ramping gaps |

## Verification
The bench builds the generator with VAL_W set to 4. This makes the full-scale limit of 15 reachable, so a sweep of fourteen growing gaps and its wrap fit in a short run. The same width still covers the clamped limits of 0 and 1, a limit of exactly 2, and limit changes that move the limit both up and down during a sweep. Starts are made by raising `enable` and by releasing `rst` while `enable` is held high. Stops are made by dropping `enable` and by asserting `rst` during a sweep.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

  // Smallest gap the generator ever produces, in clock periods.
  localparam int unsigned GAP_MIN = 2;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

endpackage

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
  import ivl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic gap_done,
  output logic start,
  output logic step,
  output logic pulse
);

  gen_state_e state_q;

  // A start is the first enabled cycle in the idle state; it fires a pulse at once.
  assign start = (state_q == GEN_IDLE) && enable;
  // The counters advance only while running and still enabled.
  assign step  = (state_q == GEN_RUN) && enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GEN_IDLE;
      pulse   <= 1'b0;
    end else begin
      pulse <= start || gap_done;
      if (start) begin
        state_q <= GEN_RUN;
      end else if ((state_q == GEN_RUN) && !enable) begin
        state_q <= GEN_IDLE;
      end
    end
  end

  // R1: reset forces the line low on the next cycle
  p_rst_quiet_r1: assert property (@(posedge clk) rst |=> !pulse);

  // R3: no pulse is longer than one cycle
  p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R9: with enable low, no pulse follows
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulse);

  // R2: a rising enable yields a pulse on the next cycle
  p_first_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> pulse);

endmodule

// File: rtl/ivl_gap_counter.sv
module ivl_gap_counter #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic [VAL_W-1:0] gap,
  output logic [VAL_W-1:0] cnt,
  output logic             done
);

  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  // cnt holds the number of periods elapsed since the last pulse.
  assign done = step && (cnt == gap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= ONE;
    end else if (step) begin
      cnt <= done ? ONE : cnt + ONE;
    end else begin
      cnt <= '0;
    end
  end

  // R4: while stepping, the count is never zero, so a gap of 2 is always reachable
  p_cnt_live_r4: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt != '0));

endmodule

// File: rtl/ivl_sweep.sv
module ivl_sweep
  import ivl_pkg::*;
#(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gap_done,
  input  logic [VAL_W-1:0] max_in,
  output logic [VAL_W-1:0] cur,
  output logic [VAL_W-1:0] lim
);

  localparam logic [VAL_W-1:0] FLOOR = VAL_W'(GAP_MIN);

  logic [VAL_W-1:0] lim_next;

  // R7: limits below the floor are raised to it
  assign lim_next = (max_in < FLOOR) ? FLOOR : max_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= FLOOR;
      lim <= FLOOR;
    end else if (start) begin
      cur <= FLOOR;
      lim <= lim_next;
    end else if (gap_done) begin
      if (cur >= lim) begin
        cur <= FLOOR;
        lim <= lim_next;
      end else begin
        cur <= cur + 1'b1;
      end
    end
  end

  // R7: the active limit never drops below the floor
  p_lim_floor_r7: assert property (@(posedge clk) disable iff (rst)
    lim >= FLOOR);

  // R6: the current gap stays inside the window from the floor to the limit
  p_cur_window_r6: assert property (@(posedge clk) disable iff (rst)
    (cur >= FLOOR) && (cur <= lim));

endmodule

// File: rtl/ramp_pulse_gen.sv
module ramp_pulse_gen #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [VAL_W-1:0] max_value,
  output logic             pulse
);

  logic             start;
  logic             step;
  logic             gap_done;
  logic [VAL_W-1:0] cnt;
  logic [VAL_W-1:0] cur;
  logic [VAL_W-1:0] lim;

  ivl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .gap_done (gap_done),
    .start    (start),
    .step     (step),
    .pulse    (pulse)
  );

  ivl_gap_counter #(.VAL_W(VAL_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .step  (step),
    .gap   (cur),
    .cnt   (cnt),
    .done  (gap_done)
  );

  ivl_sweep #(.VAL_W(VAL_W)) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .gap_done (gap_done),
    .max_in   (max_value),
    .cur      (cur),
    .lim      (lim)
  );

  // R5: the elapsed count never overtakes the gap being measured
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt <= cur));

  // R8: the limit holds steady on every running cycle that ends no gap
  p_lim_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !gap_done) |=> $stable(lim));

endmodule

// File: tb/ramp_pulse_gen_tb.sv
`timescale 1ns/1ps
module ramp_pulse_gen_tb;

  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [VW-1:0] max_value = '0;
  logic          pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seen = 0;
  bit finished = 1'b0;
  bit prev_pulse = 1'b0;

  int    q_t[$];
  string q_tag[$];

  ramp_pulse_gen #(.VAL_W(VW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .max_value (max_value),
    .pulse     (pulse)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clampi(input int m);
    return (m < 2) ? 2 : m;
  endfunction

  // Monitor: pops the expected pulse times and compares them with the observed pulses.
  always @(negedge clk) begin
    if (pulse) begin
      seen++;
      checks++;
      if (prev_pulse) begin
        errors++;
        $display("FAIL R3 pulse width: actual 2+ cycles expected 1 at cyc %0d", cyc);
      end
      checks++;
      if (q_t.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected pulse: actual cyc %0d expected none", cyc);
      end else begin
        int    et;
        string tg;
        et = q_t.pop_front();
        tg = q_tag.pop_front();
        if (et != cyc) begin
          errors++;
          $display("FAIL %s pulse time: actual %0d expected %0d", tg, cyc, et);
        end
      end
    end
    prev_pulse = pulse;
  end

  // Driver: predicts every pulse time of one run, queues them, then drives the run.
  task automatic run_phase(input int max0, input int chg_off, input int max1,
                           input int n, input bit by_rst, input bit end_rst,
                           input string tag);
    int c, t, gap, lim;
    bit wr;
    string ptag;
    c = cyc;
    max_value = VW'(max0);
    lim = clampi(max0);
    t = c + 1;
    gap = 2;
    wr = 1'b0;
    ptag = "R2";
    while (t <= c + n) begin
      q_t.push_back(t);
      q_tag.push_back(ptag);
      if (tag != "") ptag = tag;
      else if (gap != 2) ptag = "R5";
      else ptag = wr ? "R6" : "R4";
      t = t + gap;
      if (gap >= lim) begin
        gap = 2;
        lim = clampi((chg_off > 0 && t > c + chg_off) ? max1 : max0);
        wr = 1'b1;
      end else begin
        gap++;
      end
    end
    if (by_rst) rst = 1'b0;
    else enable = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (chg_off > 0 && cyc == c + chg_off) max_value = VW'(max1);
    end
    if (end_rst) rst = 1'b1;
    else enable = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (q_t.size() != 0) begin
      errors++;
      $display("FAIL %s missing pulses: actual %0d left expected 0",
               (tag != "") ? tag : "R5", q_t.size());
      q_t.delete();
      q_tag.delete();
    end
  endtask

  task automatic hold_quiet(input int n, input string tag);
    int s0;
    s0 = seen;
    repeat (n) begin
      @(negedge clk);
      checks++;
      if (pulse !== 1'b0) begin
        errors++;
        $display("FAIL %s quiet line: actual %b expected 0", tag, pulse);
      end
    end
    checks++;
    if (seen != s0) begin
      errors++;
      $display("FAIL %s pulses while stopped: actual %0d expected 0", tag, seen - s0);
    end
  endtask

  initial begin
    enable = 1'b1;
    max_value = VW'(6);
    @(negedge clk);
    hold_quiet(5, "R1");
    // Start by releasing reset, sweeps of 2..6
    run_phase(6, 0, 0, 45, 1'b1, 1'b0, "");
    hold_quiet(10, "R9");
    // Restart by enable after a stop
    run_phase(6, 0, 0, 30, 1'b0, 1'b0, "");
    // Clamped and minimum limits
    run_phase(0, 0, 0, 12, 1'b0, 1'b0, "R7");
    run_phase(1, 0, 0, 12, 1'b0, 1'b0, "R7");
    run_phase(2, 0, 0, 10, 1'b0, 1'b0, "R6");
    // Full-scale limit including its wrap
    run_phase(15, 0, 0, 140, 1'b0, 1'b0, "R10");
    // Limit changed mid-sweep, upward and downward
    run_phase(5, 5, 8, 60, 1'b0, 1'b0, "R8");
    run_phase(9, 4, 3, 60, 1'b0, 1'b0, "R8");
    // Reset during a sweep, then restart by reset release
    run_phase(6, 0, 0, 20, 1'b0, 1'b1, "");
    enable = 1'b1;
    hold_quiet(4, "R1");
    run_phase(4, 0, 0, 20, 1'b1, 1'b0, "");
    hold_quiet(5, "R9");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule